// File: doc/BRIEF.md
# ADC Result Formatter with Window Fault Pulse

This block sits after the conversion engine of an ADC controller. Each finished conversion comes in as a 12-bit sample and a 4-bit channel number. The block stores the pair in a last-result register. It builds a 16-bit half-word for a DMA engine and presents it on a valid/ready output stream. When the tag option is on, the half-word carries the channel number in its top nibble. When the tag option is off, that nibble is zero.

The same result is also compared against a programmable window. The comparison uses one of four modes and can apply either to every channel or to one selected channel. A match sets a sticky compare flag, which software clears with a status-read strobe. A match also produces a fault line meant for a PWM safe-state input. That line only ever pulses for one clock cycle, so it is a separate signal from the sticky flag. If matching results arrive faster than pulses can be kept apart, the extra matches are queued. They are then emitted as distinct pulses, each followed by a low cycle.

Stream rules:
- The input side has no back-pressure. `res_valid` is a one-cycle strobe and is always accepted.
- On the DMA side, `dma_valid` rises in the cycle after a capture. It stays high until a cycle in which `dma_ready` is high.
- If a new result arrives while a word is still unaccepted, the new word replaces the old one, `dma_valid` stays high, and the overrun flag is set.

Top module: `adc_result_stage`

## Requirements
- R1: A result sampled with `res_valid` high at a clock edge appears on `last_value` and `last_chan` directly after that edge.
- R2: `dma_valid` is high after every edge that captures a result. It remains high, with `dma_data` unchanged, until an edge where `dma_ready` is high and no new result arrives. After such an edge it goes low.
- R3: `dma_data[11:0]` holds the captured value. `dma_data[15:12]` holds the captured channel when `tag_en` was high at capture, and is zero otherwise.
- R4: `win_mode` selects the match condition: 0 for value < `thr_lo`, 1 for value > `thr_hi`, 2 for `thr_lo` <= value <= `thr_hi`, and 3 for value < `thr_lo` or value > `thr_hi`.
- R5: With `win_all` high, every channel is compared. With `win_all` low, only results whose channel equals `win_chan` can match.
- R6: `fault_pulse` is never high in two consecutive cycles. When no earlier pulse is queued or active, a matching result raises it directly after the capturing edge, for exactly one cycle.
- R7: Matching results on consecutive edges each yield their own pulse. Three back-to-back matches give the output pattern high, low, high, low, high, low.
- R8: `win_flag` is set by any match and stays set until a cycle with `stat_clr` high. A match in that same cycle takes priority and keeps the flag set.
- R9: A result captured while `dma_valid` is high and `dma_ready` is low sets `ovr_flag`. The flag stays set until `stat_clr`.
- R10: After reset, `dma_valid`, `fault_pulse`, `win_flag` and `ovr_flag` are low, and the last-result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe for a finished conversion |
| res_value | input | 12 | Converted sample |
| res_chan | input | 4 | Channel number of the sample |
| tag_en | input | 1 | Put the channel number into the top nibble of the DMA word |
| win_mode | input | 2 | Compare mode (see R4) |
| win_all | input | 1 | Compare every channel |
| win_chan | input | 4 | Channel compared when `win_all` is low |
| thr_lo | input | 12 | Low threshold |
| thr_hi | input | 12 | High threshold |
| stat_clr | input | 1 | Status-read strobe that clears the sticky flags |
| dma_ready | input | 1 | DMA side accepts the word |
| dma_valid | output | 1 | DMA request |
| dma_data | output | 16 | Formatted half-word |
| last_value | output | 12 | Last captured value |
| last_chan | output | 4 | Last captured channel |
| fault_pulse | output | 1 | One-cycle fault pulse |
| win_flag | output | 1 | Sticky compare event |
| ovr_flag | output | 1 | Sticky DMA overrun |

## Verification
The hardest state to reach is a backlog in the pulse queue. It needs matching results on consecutive edges, so that a match lands while a pulse is already on the line. The bench drives three matching results on three adjacent edges and records `fault_pulse` over the next six cycles. Overrun is reached by holding `dma_ready` low across two captures and then checking that the newer word is the one on offer.

// File: rtl/adc_rs_pkg.sv
package adc_rs_pkg;
  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ABOVE   = 2'd1,
    CMP_INSIDE  = 2'd2,
    CMP_OUTSIDE = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/adc_rs_window.sv
module adc_rs_window #(
  parameter int VAL_W = 12,
  parameter int CH_W  = 4
) (
  input  logic [VAL_W-1:0] value_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [1:0]       mode_i,
  input  logic             all_i,
  input  logic [CH_W-1:0]  sel_i,
  input  logic [VAL_W-1:0] lo_i,
  input  logic [VAL_W-1:0] hi_i,
  output logic             hit_o
);
  import adc_rs_pkg::*;
  logic below, above, cond, chan_ok;

  always_comb begin
    below   = value_i < lo_i;
    above   = value_i > hi_i;
    chan_ok = all_i || (chan_i == sel_i);
    unique case (cmp_mode_e'(mode_i))
      CMP_BELOW:   cond = below;
      CMP_ABOVE:   cond = above;
      CMP_INSIDE:  cond = !below && !above;
      CMP_OUTSIDE: cond = below || above;
      default:     cond = 1'b0;
    endcase
    hit_o = cond && chan_ok;
  end
endmodule

// File: rtl/adc_rs_dma.sv
module adc_rs_dma #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              overrun_o
);
  // A load while a word is still unaccepted replaces that word.
  assign overrun_o = load_i && valid_o && !ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= word_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rs_fault.sv
module adc_rs_fault #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic pulse_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  logic [PEND_W-1:0] pend_q;
  logic              emit;

  // A pulse fires only after a low cycle; matches that arrive meanwhile wait in the queue.
  assign emit = !pulse_o && (hit_i || pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      pend_q  <= '0;
    end else begin
      pulse_o <= emit;
      if (hit_i && !emit && pend_q != PEND_MAX)
        pend_q <= pend_q + 1'b1;
      else if (!hit_i && emit)
        pend_q <= pend_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage #(
  parameter int VAL_W  = 12,
  parameter int CH_W   = 4,
  parameter int WORD_W = 16,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [VAL_W-1:0]  res_value,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              tag_en,
  input  logic [1:0]        win_mode,
  input  logic              win_all,
  input  logic [CH_W-1:0]   win_chan,
  input  logic [VAL_W-1:0]  thr_lo,
  input  logic [VAL_W-1:0]  thr_hi,
  input  logic              stat_clr,
  input  logic              dma_ready,
  output logic              dma_valid,
  output logic [WORD_W-1:0] dma_data,
  output logic [VAL_W-1:0]  last_value,
  output logic [CH_W-1:0]   last_chan,
  output logic              fault_pulse,
  output logic              win_flag,
  output logic              ovr_flag
);
  localparam int PAD_W = WORD_W - VAL_W - CH_W;

  logic              hit, match, ovr_hit;
  logic [CH_W-1:0]   tag_field;
  logic [WORD_W-1:0] word;

  assign tag_field = tag_en ? res_chan : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {tag_field, {PAD_W{1'b0}}, res_value};
    end else begin : g_nopad
      assign word = {tag_field, res_value};
    end
  endgenerate

  adc_rs_window #(.VAL_W(VAL_W), .CH_W(CH_W)) win_i (
    .value_i(res_value), .chan_i(res_chan), .mode_i(win_mode),
    .all_i(win_all), .sel_i(win_chan), .lo_i(thr_lo), .hi_i(thr_hi),
    .hit_o(hit)
  );

  assign match = res_valid && hit;

  adc_rs_dma #(.WORD_W(WORD_W)) dma_i (
    .clk(clk), .rst_n(rst_n), .load_i(res_valid), .word_i(word),
    .ready_i(dma_ready), .valid_o(dma_valid), .data_o(dma_data),
    .overrun_o(ovr_hit)
  );

  adc_rs_fault #(.PEND_W(PEND_W)) flt_i (
    .clk(clk), .rst_n(rst_n), .hit_i(match), .pulse_o(fault_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_value <= '0;
      last_chan  <= '0;
      win_flag   <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      if (res_valid) begin
        last_value <= res_value;
        last_chan  <= res_chan;
      end
      if (match)         win_flag <= 1'b1;
      else if (stat_clr) win_flag <= 1'b0;
      if (ovr_hit)       ovr_flag <= 1'b1;
      else if (stat_clr) ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rs_chk.sv
module adc_rs_chk #(
  parameter int VAL_W  = 12,
  parameter int CH_W   = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [VAL_W-1:0]  res_value,
  input logic [CH_W-1:0]   res_chan,
  input logic              tag_en,
  input logic              stat_clr,
  input logic              dma_ready,
  input logic              dma_valid,
  input logic [WORD_W-1:0] dma_data,
  input logic [VAL_W-1:0]  last_value,
  input logic              fault_pulse,
  input logic              win_flag,
  input logic              ovr_flag
);
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> last_value == $past(res_value));
  assert_req_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> dma_valid);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready && !res_valid |=> dma_valid && $stable(dma_data));
  assert_untagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !tag_en |=> dma_data[WORD_W-1 -: CH_W] == '0);
  assert_tagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && tag_en |=> dma_data[WORD_W-1 -: CH_W] == $past(res_chan));
  assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_flag && !stat_clr |=> win_flag);
  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && dma_valid && !dma_ready |=> ovr_flag);
endmodule

bind adc_result_stage adc_rs_chk #(.VAL_W(VAL_W), .CH_W(CH_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
  .res_chan(res_chan), .tag_en(tag_en), .stat_clr(stat_clr),
  .dma_ready(dma_ready), .dma_valid(dma_valid), .dma_data(dma_data),
  .last_value(last_value), .fault_pulse(fault_pulse), .win_flag(win_flag),
  .ovr_flag(ovr_flag)
);

// File: tb/adc_result_stage_tb.sv
module adc_result_stage_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 1'b0, tag_en = 1'b1, win_all = 1'b1, stat_clr = 1'b0, dma_ready = 1'b1;
  logic [11:0] res_value = '0, thr_lo = 12'd1000, thr_hi = 12'd3000;
  logic [3:0]  res_chan = '0, win_chan = '0;
  logic [1:0]  win_mode = '0;
  logic        dma_valid, fault_pulse, win_flag, ovr_flag;
  logic [15:0] dma_data;
  logic [11:0] last_value;
  logic [3:0]  last_chan;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_stage dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
    .res_chan(res_chan), .tag_en(tag_en), .win_mode(win_mode), .win_all(win_all),
    .win_chan(win_chan), .thr_lo(thr_lo), .thr_hi(thr_hi), .stat_clr(stat_clr),
    .dma_ready(dma_ready), .dma_valid(dma_valid), .dma_data(dma_data),
    .last_value(last_value), .last_chan(last_chan), .fault_pulse(fault_pulse),
    .win_flag(win_flag), .ovr_flag(ovr_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit want_hit(input int mode, input int v, input int lo, input int hi);
    case (mode)
      0: return v < lo;
      1: return v > hi;
      2: return v >= lo && v <= hi;
      default: return v < lo || v > hi;
    endcase
  endfunction

  // Drives one result at a negedge; returns at the negedge after the capturing edge.
  task automatic push(input int v, input int ch);
    res_valid = 1'b1; res_value = 12'(v); res_chan = 4'(ch);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear_status();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int vals[9] = '{0, 999, 1000, 1001, 2000, 2999, 3000, 3001, 4095};
    bit seq[6];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 dma_valid", dma_valid, 0);
    chk("R10 fault", fault_pulse, 0);
    chk("R10 win_flag", win_flag, 0);
    chk("R10 ovr_flag", ovr_flag, 0);
    chk("R10 last_value", last_value, 0);

    // Sweep all modes over boundary values (R1-style capture, R3 tag, R4 modes, R6 pulse, R8 flag)
    for (int m = 0; m < 4; m++) begin
      win_mode = 2'(m);
      for (int i = 0; i < 9; i++) begin
        bit h;
        int ch;
        ch = (i + 4 * m) % 16;
        tag_en = (i % 2) == 0;
        h = want_hit(m, vals[i], 1000, 3000);
        push(vals[i], ch);
        chk("R1 last_value", last_value, 32'(vals[i]));
        chk("R1 last_chan", last_chan, 32'(ch));
        chk("R2 dma_valid raised", dma_valid, 1);
        chk("R3 dma_data", dma_data, tag_en ? ((ch << 12) | vals[i]) : vals[i]);
        chk("R4 fault", fault_pulse, 32'(h));
        chk("R8 win_flag", win_flag, 32'(h));
        clear_status();
        chk("R2 dma_valid dropped", dma_valid, 0);
        chk("R6 fault width", fault_pulse, 0);
        chk("R8 win_flag cleared", win_flag, 0);
      end
    end

    // R5: channel gating
    tag_en = 1'b1; win_all = 1'b0; win_chan = 4'd5; win_mode = 2'd3;
    push(4095, 6);
    chk("R5 other channel no fault", fault_pulse, 0);
    chk("R5 other channel no flag", win_flag, 0);
    push(4095, 5);
    chk("R5 selected channel fault", fault_pulse, 1);
    chk("R5 selected channel flag", win_flag, 1);
    @(negedge clk);
    // R8: flag sticky with no clear
    chk("R8 win_flag held", win_flag, 1);
    clear_status();
    chk("R8 win_flag cleared", win_flag, 0);

    // R8: match in the clear cycle wins
    stat_clr = 1'b1;
    push(0, 5);
    stat_clr = 1'b0;
    chk("R8 set beats clear", win_flag, 1);
    clear_status();
    @(negedge clk);

    // R7: three back-to-back matches
    win_all = 1'b1;
    res_valid = 1'b1; res_value = 12'd10; res_chan = 4'd1;
    @(negedge clk);
    seq[0] = fault_pulse;
    @(negedge clk);
    seq[1] = fault_pulse;
    @(negedge clk);
    res_valid = 1'b0;
    seq[2] = fault_pulse;
    for (int k = 3; k < 6; k++) begin
      @(negedge clk);
      seq[k] = fault_pulse;
    end
    for (int k = 0; k < 6; k++)
      chk("R7 pulse pattern", seq[k], 32'((k % 2) == 0));
    @(negedge clk);
    chk("R7 queue drained", fault_pulse, 0);
    chk("R9 no overrun with ready", ovr_flag, 0);
    clear_status();

    // R9: overrun while the request is unaccepted
    win_mode = 2'd1;
    dma_ready = 1'b0;
    push(100, 1);
    chk("R9 no overrun yet", ovr_flag, 0);
    push(200, 2);
    chk("R9 overrun set", ovr_flag, 1);
    chk("R2 newer word offered", dma_data, (2 << 12) | 200);
    @(negedge clk);
    chk("R2 held without ready", dma_valid, 1);
    chk("R2 data stable", dma_data, (2 << 12) | 200);
    chk("R9 overrun sticky", ovr_flag, 1);
    dma_ready = 1'b1;
    @(negedge clk);
    chk("R2 accepted", dma_valid, 0);
    clear_status();
    chk("R9 overrun cleared", ovr_flag, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule